// File: doc/BRIEF.md
# Change-Bit Selective Invalidation Cache

A small direct-mapped data cache with one data word per line, meant for a processor that shares memory with other agents and relies on software to decide when cached copies may be out of date. Beside its tag and data, every line carries a change bit, which flags the word as possibly out of date, and a clear bit, which flags the line as empty. A single-cycle invalidate command raises every change bit without throwing any data away. A single-cycle clear command empties the whole cache. Each read carries a kind tag. A safe read hits on any matching word. An unsafe read hits only if the word's change bit is low, and otherwise refetches the word from memory.

An optional stale-bit mode (parameter `STALE_EN`) extends the life of a word by one invalidate period. A word that has been read unsafely, written or refilled since the last invalidate keeps its change bit low through the next invalidate.

The processor side is a request port with a one-cycle lookup and a registered response. The memory side has a refill read channel and a write-through channel. Writes always allocate and are passed to memory in the cycle after they are accepted.

Top module: `selinv_cache`

## Requirements
- R1: After reset every line is empty, so every read kind misses. `req_ready` is 1, and `rsp_valid`, `mem_rd_req` and `mem_wr_en` are 0.
- R2: A safe read (`req_unsafe`=0) whose tag matches a non-empty line hits, whatever the line's change bit, and returns the cached word even if memory has since changed.
- R3: An unsafe read (`req_unsafe`=1) that matches a line whose change bit is 1 misses and returns the word fetched from memory.
- R4: Any hit, any write and any refill clears the change bit of the word it touches.
- R5: With `STALE_EN`=0, an invalidate sets the change bit of every line in one cycle and keeps all data and tags.
- R6: A clear command makes every line empty in one cycle, so later reads of both kinds miss until the line is written or refilled.
- R7: A write is accepted in one cycle, updates the cache line, and in the next cycle drives `mem_wr_en`=1 with the same address and data.
- R8: With `STALE_EN`=1, each line has a stale bit. It is set by reset, and it is cleared by an unsafe hit, a write or a refill. An invalidate copies every stale bit into the change bit and then sets all stale bits.
- R9: A read is accepted at edge 0. At edge 2 it either gives `rsp_valid` with `rsp_hit`=1, or gives a one-cycle `mem_rd_req`. After a miss, `req_ready` stays 0 until the refill returns. One cycle after `mem_rd_valid`, the refilled word appears with `rsp_hit`=0.
- R10: A command that arrives during a refill is held and applied in the first idle cycle after the refill completes. `req_ready` is 0 in any cycle in which a command is present or pending.
- R11: A read whose tag differs from the stored tag misses for either kind, and the refill replaces the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_unsafe | input | 1 | Read kind: 1 = unsafe (honours change bit), 0 = safe |
| req_addr | input | ADDR_W | Word address; low IDX_W bits index the line |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response present (one cycle) |
| rsp_hit | output | 1 | 1 if the response came from the cache |
| rsp_rdata | output | DATA_W | Read data |
| cmd_inval | input | 1 | Bulk invalidate pulse |
| cmd_clear | input | 1 | Bulk clear pulse |
| mem_rd_req | output | 1 | Refill request pulse |
| mem_rd_addr | output | ADDR_W | Refill address |
| mem_rd_valid | input | 1 | Refill data present (one cycle) |
| mem_rd_data | input | DATA_W | Refill data |
| mem_wr_en | output | 1 | Write-through strobe |
| mem_wr_addr | output | ADDR_W | Write-through address |
| mem_wr_data | output | DATA_W | Write-through data |

## Verification
The assertions assume that memory raises `mem_rd_valid` for exactly one cycle, and only after a `mem_rd_req` that has not yet been answered. They also assume that memory takes every write-through beat without back-pressure. The bench memory model answers each refill request once, after a fixed two-cycle delay, and it absorbs writes in the cycle they appear. The bench raises commands as single-cycle pulses. It starts a new request only after both instances have answered the previous one, so the stimulus never relies on a response that the assertions do not cover.

// File: rtl/selinv_pkg.sv
package selinv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WAIT = 2'd2
  } selinv_state_e;
endpackage

// File: rtl/selinv_ram.sv
module selinv_ram #(
  parameter int AW = 4,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [0:DEPTH-1];

  // read-first single port, output registered
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/selinv_status.sv
module selinv_status #(
  parameter int IDX_W    = 4,
  parameter bit STALE_EN = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] look_idx,
  output logic             chg_o,
  output logic             clr_o,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             hit_unsafe,
  input  logic             inval_en,
  input  logic             clear_en
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] chg;
  logic [LINES-1:0] clr;
  logic [LINES-1:0] inval_val;

  assign chg_o = chg[look_idx];
  assign clr_o = clr[look_idx];

  // bulk operations only occur in idle cycles with no request, so
  // they never coincide with per-word updates
  always_ff @(posedge clk) begin
    if (rst) begin
      chg <= '0;
      clr <= '1;
    end else begin
      if (inval_en) chg <= inval_val;
      if (clear_en) clr <= '1;
      if (hit_en) chg[hit_idx] <= 1'b0;
      if (fill_en) begin
        chg[fill_idx] <= 1'b0;
        clr[fill_idx] <= 1'b0;
      end
    end
  end

  generate
    if (STALE_EN) begin : g_stale
      logic [LINES-1:0] stl;
      always_ff @(posedge clk) begin
        if (rst) begin
          stl <= '1;
        end else begin
          if (inval_en) stl <= '1;
          if (fill_en) stl[fill_idx] <= 1'b0;
          if (hit_en && hit_unsafe) stl[hit_idx] <= 1'b0;
        end
      end
      assign inval_val = stl;
    end else begin : g_plain
      logic unused_hit_kind;
      assign unused_hit_kind = hit_unsafe;
      assign inval_val = '1;
    end
  endgenerate
endmodule

// File: rtl/selinv_cache.sv
module selinv_cache
  import selinv_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 4,
  parameter bit STALE_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_unsafe,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              cmd_inval,
  input  logic              cmd_clear,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int RAM_W = TAG_W + DATA_W;

  selinv_state_e     state;
  logic [ADDR_W-1:0] r_addr;
  logic              r_unsafe;
  logic              pend_inv;
  logic              pend_clr;

  logic [IDX_W-1:0] req_idx, r_idx;
  logic [TAG_W-1:0] req_tag, r_tag;
  assign req_idx = req_addr[IDX_W-1:0];
  assign req_tag = req_addr[ADDR_W-1:IDX_W];
  assign r_idx   = r_addr[IDX_W-1:0];
  assign r_tag   = r_addr[ADDR_W-1:IDX_W];

  logic idle, refill, do_inv, do_clr, acc, acc_wr;
  assign idle   = (state == ST_IDLE);
  assign refill = (state == ST_WAIT) && mem_rd_valid;
  assign do_inv = idle && (cmd_inval || pend_inv);
  assign do_clr = idle && (cmd_clear || pend_clr);
  assign req_ready = idle && !cmd_inval && !cmd_clear && !pend_inv && !pend_clr;
  assign acc    = req_valid && req_ready;
  assign acc_wr = acc && req_write;

  // line storage: {tag, data}
  logic             ram_we;
  logic [IDX_W-1:0] ram_addr;
  logic [RAM_W-1:0] ram_wdata, ram_q;
  assign ram_we    = acc_wr || refill;
  assign ram_addr  = refill ? r_idx : req_idx;
  assign ram_wdata = refill ? {r_tag, mem_rd_data} : {req_tag, req_wdata};

  selinv_ram #(.AW(IDX_W), .W(RAM_W)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .addr (ram_addr),
    .wdata(ram_wdata),
    .rdata(ram_q)
  );

  logic chg_bit, clr_bit, look_hit;
  assign look_hit = !clr_bit && (ram_q[RAM_W-1:DATA_W] == r_tag) &&
                    !(r_unsafe && chg_bit);

  selinv_status #(.IDX_W(IDX_W), .STALE_EN(STALE_EN)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .look_idx  (r_idx),
    .chg_o     (chg_bit),
    .clr_o     (clr_bit),
    .fill_en   (acc_wr || refill),
    .fill_idx  (refill ? r_idx : req_idx),
    .hit_en    ((state == ST_LOOK) && look_hit),
    .hit_idx   (r_idx),
    .hit_unsafe(r_unsafe),
    .inval_en  (do_inv),
    .clear_en  (do_clr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      r_addr      <= '0;
      r_unsafe    <= 1'b0;
      pend_inv    <= 1'b0;
      pend_clr    <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_rdata   <= '0;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
    end else begin
      rsp_valid  <= 1'b0;
      mem_rd_req <= 1'b0;
      mem_wr_en  <= 1'b0;
      pend_inv   <= idle ? 1'b0 : (pend_inv || cmd_inval);
      pend_clr   <= idle ? 1'b0 : (pend_clr || cmd_clear);
      case (state)
        ST_IDLE: begin
          if (acc) begin
            if (req_write) begin
              mem_wr_en   <= 1'b1;
              mem_wr_addr <= req_addr;
              mem_wr_data <= req_wdata;
            end else begin
              r_addr   <= req_addr;
              r_unsafe <= req_unsafe;
              state    <= ST_LOOK;
            end
          end
        end
        ST_LOOK: begin
          if (look_hit) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_rdata <= ram_q[DATA_W-1:0];
            state     <= ST_IDLE;
          end else begin
            mem_rd_req  <= 1'b1;
            mem_rd_addr <= r_addr;
            state       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rd_valid) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b0;
            rsp_rdata <= mem_rd_data;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/selinv_check.sv
module selinv_check #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              cmd_inval,
  input logic              cmd_clear,
  input logic              mem_rd_req,
  input logic              mem_rd_valid,
  input logic [DATA_W-1:0] mem_rd_data,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data
);
  logic outstanding;
  always_ff @(posedge clk) begin
    if (rst) outstanding <= 1'b0;
    else if (mem_rd_req) outstanding <= 1'b1;
    else if (mem_rd_valid) outstanding <= 1'b0;
  end

  // R1: outputs quiet in the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!rsp_valid && !mem_rd_req && !mem_wr_en));

  // R7: write-through one cycle after acceptance, no read response
  a_r7_write_through: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_write) |=>
      (mem_wr_en && mem_wr_addr == $past(req_addr) &&
       mem_wr_data == $past(req_wdata) && !rsp_valid));

  // R9: lookup cycle is silent, second cycle answers or requests refill
  a_r9_lookup_silent: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write) |=> (!rsp_valid && !mem_rd_req && !req_ready));

  a_r9_two_cycle_outcome: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write) |-> ##2 (rsp_valid ^ mem_rd_req));

  // R9: port stalled while a refill is outstanding
  a_r9_stall_on_refill: assert property (@(posedge clk) disable iff (rst)
    outstanding |-> !req_ready);

  // R9: refill data delivered as a miss response
  a_r9_refill_delivered: assert property (@(posedge clk) disable iff (rst)
    (outstanding && mem_rd_valid) |=>
      (rsp_valid && !rsp_hit && rsp_rdata == $past(mem_rd_data)));

  // R10: a command blocks request acceptance in its cycle
  a_r10_cmd_blocks: assert property (@(posedge clk) disable iff (rst)
    (cmd_inval || cmd_clear) |-> !req_ready);
endmodule

bind selinv_cache selinv_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_rdata   (rsp_rdata),
  .cmd_inval   (cmd_inval),
  .cmd_clear   (cmd_clear),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_valid(mem_rd_valid),
  .mem_rd_data (mem_rd_data),
  .mem_wr_en   (mem_wr_en),
  .mem_wr_addr (mem_wr_addr),
  .mem_wr_data (mem_wr_data)
);

// File: tb/sim_selinv_cache.sv
module sim_selinv_cache;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic        req_valid = 1'b0, req_write = 1'b0, req_unsafe = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        cmd_inval = 1'b0, cmd_clear = 1'b0;

  logic        rdy0, rv0, rh0, mrq0, mwe0;
  logic [31:0] rd0, mwd0;
  logic [11:0] mra0, mwa0;
  logic        rdy1, rv1, rh1, mrq1, mwe1;
  logic [31:0] rd1, mwd1;
  logic [11:0] mra1, mwa1;
  logic        mrv0, mrv1;
  logic [31:0] mrd0, mrd1;

  selinv_cache #(.STALE_EN(1'b0)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy0),
    .req_write(req_write), .req_unsafe(req_unsafe), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rv0), .rsp_hit(rh0), .rsp_rdata(rd0),
    .cmd_inval(cmd_inval), .cmd_clear(cmd_clear), .mem_rd_req(mrq0),
    .mem_rd_addr(mra0), .mem_rd_valid(mrv0), .mem_rd_data(mrd0),
    .mem_wr_en(mwe0), .mem_wr_addr(mwa0), .mem_wr_data(mwd0));

  selinv_cache #(.STALE_EN(1'b1)) u1 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy1),
    .req_write(req_write), .req_unsafe(req_unsafe), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rv1), .rsp_hit(rh1), .rsp_rdata(rd1),
    .cmd_inval(cmd_inval), .cmd_clear(cmd_clear), .mem_rd_req(mrq1),
    .mem_rd_addr(mra1), .mem_rd_valid(mrv1), .mem_rd_data(mrd1),
    .mem_wr_en(mwe1), .mem_wr_addr(mwa1), .mem_wr_data(mwd1));

  // shared memory model: 256 words keyed by addr[7:0], two-cycle refill delay
  logic [31:0] mem [0:255];
  logic        ext_we = 1'b0;
  logic [7:0]  ext_a = '0;
  logic [31:0] ext_d = '0;
  logic        pa0, pb0, pa1, pb1;
  logic [7:0]  ra0, ra1;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'hC0DE_0000 | i;
      {pa0, pb0, mrv0, pa1, pb1, mrv1} <= '0;
      ra0 <= '0; ra1 <= '0; mrd0 <= '0; mrd1 <= '0;
    end else begin
      if (mwe0) mem[mwa0[7:0]] <= mwd0;
      if (ext_we) mem[ext_a] <= ext_d;
      pa0 <= mrq0; pb0 <= pa0; mrv0 <= pb0;
      pa1 <= mrq1; pb1 <= pa1; mrv1 <= pb1;
      if (mrq0) ra0 <= mra0[7:0];
      if (mrq1) ra1 <= mra1[7:0];
      mrd0 <= mem[ra0];
      mrd1 <= mem[ra1];
    end
  end

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_read(input logic u, input logic [11:0] a, input logic eh0,
                         input logic eh1, input logic [31:0] ed0,
                         input logic [31:0] ed1, input string rq);
    logic g0, g1, h0, h1;
    logic [31:0] d0, d1;
    g0 = 0; g1 = 0; h0 = 0; h1 = 0; d0 = '0; d1 = '0;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_unsafe = u; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 20 && !(g0 && g1); i++) begin
      @(negedge clk);
      if (rv0) begin g0 = 1; h0 = rh0; d0 = rd0; end
      if (rv1) begin g1 = 1; h1 = rh1; d1 = rd1; end
    end
    chk(g0 && h0 == eh0, {rq, " u0 hit"}, {31'd0, h0}, {31'd0, eh0});
    chk(g0 && d0 == ed0, {rq, " u0 data"}, d0, ed0);
    chk(g1 && h1 == eh1, {rq, " u1 hit"}, {31'd0, h1}, {31'd0, eh1});
    chk(g1 && d1 == ed1, {rq, " u1 data"}, d1, ed1);
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d,
                          input string rq);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    chk(mwe0 && mwa0 == a, {rq, " wr addr"}, {20'd0, mwa0}, {20'd0, a});
    chk(mwd0 == d, {rq, " wr data"}, mwd0, d);
  endtask

  task automatic do_cmd(input logic inv, input logic clr, input string rq);
    @(negedge clk);
    cmd_inval = inv; cmd_clear = clr;
    #1;
    chk(!rdy0 && !rdy1, {rq, " ready during cmd"}, {31'd0, rdy0}, 32'd0);
    @(negedge clk);
    cmd_inval = 0; cmd_clear = 0;
  endtask

  task automatic do_ext(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    ext_we = 1; ext_a = a; ext_d = d;
    @(negedge clk);
    ext_we = 0;
  endtask

  typedef struct packed {
    logic [2:0]  op;    // 0 read, 1 write, 2 invalidate, 3 clear, 4 external memory write
    logic        mr;    // read kind: 1 unsafe
    logic [11:0] addr;
    logic [31:0] wd;
    logic        h0;    // expected hit, plain instance
    logic        h1;    // expected hit, stale-bit instance
    logic [31:0] e0;
    logic [31:0] e1;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    {3'd0,1'b0,12'h005,32'h0,1'b0,1'b0,32'hC0DE0005,32'hC0DE0005,4'd1},  // R1 empty after reset
    {3'd0,1'b0,12'h005,32'h0,1'b1,1'b1,32'hC0DE0005,32'hC0DE0005,4'd2},  // R2
    {3'd0,1'b1,12'h005,32'h0,1'b1,1'b1,32'hC0DE0005,32'hC0DE0005,4'd4},  // R4 refill cleared change
    {3'd0,1'b1,12'h007,32'h0,1'b0,1'b0,32'hC0DE0007,32'hC0DE0007,4'd1},  // R1
    {3'd1,1'b0,12'h006,32'h11110006,1'b0,1'b0,32'h0,32'h0,4'd7},         // R7
    {3'd0,1'b1,12'h006,32'h0,1'b1,1'b1,32'h11110006,32'h11110006,4'd7},  // R7 allocate
    {3'd4,1'b0,12'h005,32'h22220005,1'b0,1'b0,32'h0,32'h0,4'd3},         // R3 another agent writes
    {3'd2,1'b0,12'h000,32'h0,1'b0,1'b0,32'h0,32'h0,4'd5},                // R5 invalidate
    {3'd0,1'b0,12'h005,32'h0,1'b1,1'b1,32'hC0DE0005,32'hC0DE0005,4'd5},  // R5 data kept, R2
    {3'd0,1'b1,12'h006,32'h0,1'b0,1'b1,32'h11110006,32'h11110006,4'd3},  // R3 plain miss, R8 stale hit
    {3'd0,1'b1,12'h005,32'h0,1'b1,1'b1,32'hC0DE0005,32'hC0DE0005,4'd4},  // R4 safe hit cleared change
    {3'd2,1'b0,12'h000,32'h0,1'b0,1'b0,32'h0,32'h0,4'd8},                // R8 second invalidate
    {3'd0,1'b1,12'h007,32'h0,1'b0,1'b0,32'hC0DE0007,32'hC0DE0007,4'd8},  // R8 stale copied to change
    {3'd0,1'b1,12'h005,32'h0,1'b0,1'b1,32'h22220005,32'hC0DE0005,4'd8},  // R8 life extended
    {3'd0,1'b0,12'h015,32'h0,1'b0,1'b0,32'hC0DE0015,32'hC0DE0015,4'd11}, // R11 tag conflict
    {3'd0,1'b0,12'h005,32'h0,1'b0,1'b0,32'h22220005,32'h22220005,4'd11}, // R11 replaced
    {3'd3,1'b0,12'h000,32'h0,1'b0,1'b0,32'h0,32'h0,4'd6},                // R6 clear
    {3'd0,1'b0,12'h005,32'h0,1'b0,1'b0,32'h22220005,32'h22220005,4'd6},  // R6 safe read misses
    {3'd0,1'b1,12'h006,32'h0,1'b0,1'b0,32'h11110006,32'h11110006,4'd6},  // R6 unsafe read misses
    {3'd0,1'b1,12'h006,32'h0,1'b1,1'b1,32'h11110006,32'h11110006,4'd4}   // R4 refill clears change
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state at the ports
    chk(rdy0 && rdy1, "R1 ready", {31'd0, rdy0}, 32'd1);
    chk(!rv0 && !rv1, "R1 rsp_valid", {31'd0, rv0}, 32'd0);
    chk(!mrq0 && !mrq1, "R1 mem_rd_req", {31'd0, mrq0}, 32'd0);
    chk(!mwe0 && !mwe1, "R1 mem_wr_en", {31'd0, mwe0}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      string tag;
      v = VEC[k];
      tag = $sformatf("R%0d vec%0d", v.rq, k);
      case (v.op)
        3'd0: do_read(v.mr, v.addr, v.h0, v.h1, v.e0, v.e1, tag);
        3'd1: do_write(v.addr, v.wd, tag);
        3'd2: do_cmd(1'b1, 1'b0, tag);
        3'd3: do_cmd(1'b0, 1'b1, tag);
        default: do_ext(v.addr[7:0], v.wd);
      endcase
    end

    // R9: hit timing, line 0x006 is cached with change bit low
    @(negedge clk);
    req_valid = 1; req_write = 0; req_unsafe = 1; req_addr = 12'h006;
    @(negedge clk);
    req_valid = 0;
    chk(!rv0 && !mrq0, "R9 lookup cycle silent", {31'd0, rv0}, 32'd0);
    chk(!rdy0, "R9 busy in lookup", {31'd0, rdy0}, 32'd0);
    @(negedge clk);
    chk(rv0 && rh0, "R9 hit after two edges", {31'd0, rv0 & rh0}, 32'd1);
    chk(rd0 == 32'h11110006, "R9 hit data", rd0, 32'h11110006);

    // R9 and R10: miss on empty line, invalidate arrives during refill
    @(negedge clk);
    req_valid = 1; req_unsafe = 1; req_addr = 12'h02A;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    chk(mrq0 && mra0 == 12'h02A, "R9 refill request", {20'd0, mra0}, 32'h02A);
    chk(!rdy0, "R9 stall at refill", {31'd0, rdy0}, 32'd0);
    cmd_inval = 1;
    @(negedge clk);
    cmd_inval = 0;
    chk(!rdy0 && !rv0, "R9 still stalled", {31'd0, rdy0}, 32'd0);
    begin
      bit g0, g1;
      g0 = 0; g1 = 0;
      for (int i = 0; i < 20 && !(g0 && g1); i++) begin
        if (!g0 && rv0) begin
          g0 = 1;
          chk(!rh0 && rd0 == 32'hC0DE002A, "R9 refill data", rd0, 32'hC0DE002A);
          chk(!rdy0, "R10 pending command holds port", {31'd0, rdy0}, 32'd0);
        end
        if (rv1) g1 = 1;
        if (!(g0 && g1)) @(negedge clk);
      end
      chk(g0 && g1, "R9 refill completed", {31'd0, g0}, 32'd1);
    end
    // invalidate applied after refill: plain instance misses, stale one keeps it
    do_read(1'b1, 12'h02A, 1'b0, 1'b1, 32'hC0DE002A, 32'hC0DE002A, "R10 deferred invalidate");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule